// File: doc/BRIEF.md
# Pin-Selected Clock Divider with Output State Control

This block derives two clock outputs from one source clock through three 7-bit integer dividers. Three external select pins form an index into eight stored per-setting bits. Each bit decides which of two programmable 2-bit output-state codes is in force. The state code sets whether the outputs run, are three-stated, are held low, or are powered down.

Each output has a route field that picks which divider feeds it. Each divider holds its ratio and state code until its current output period ends, so a change on a select pin or a ratio field never cuts a pulse short. The select pins and the configuration fields are taken to be synchronous to the source clock. The analog drivers act on the output-enable signals. The frequency synthesis upstream of the source clock belongs to other blocks.

The configuration values after a power-on reset, which the integration ties or loads, are these. State code A is 01 and state code B is 11. Only setting 1 selects code B. Output 1 uses divider 2, output 2 uses divider 3, and every ratio is 1.

Top module: `pinsel_clkdiv`

## Requirements
- R1: While rst_n is low, y1_clk, y2_clk, y1_oe, y2_oe and pwr_down are all 0.
- R2: The value on sel_pin (0 to 7) picks bit sel_pin of set_pick. A 0 in that bit applies state code st_def0 and a 1 applies st_def1.
- R3: With state code 11 on the selected divider, the output drives that divider's clock and its output enable is 1.
- R4: With state code 01, the output enable is 0 and the output reads 0, while the divider keeps counting.
- R5: With state code 10, the output enable is 1 and the output is low. The divider counter stays at zero, so after a return to 11 the first source cycle of the output is its high phase (for ratios of 2 or more).
- R6: With state code 00, the output enable is 0 and the output reads 0. The divider is held, and pwr_down is 1 starting one source cycle after code 00 is applied, for as long as the code stays 00.
- R7: A ratio N of 2 or more gives a period of N source cycles: high for floor(N/2) cycles from the start of the period, then low for the rest.
- R8: A ratio of 1 on a running divider passes the source clock straight through.
- R9: A ratio of 0 puts the divider in standby, and its output stays low.
- R10: A new ratio or state code is taken up only at the end of a divider's current period. A divider that is idle (ratio 0, or code 00 or 10) takes it up on the next source edge.
- R11: y1_route = 0 routes divider 1 to output 1, and 1 routes divider 2.
- R12: y2_route = 00, 01 and 10 route dividers 1, 2 and 3 to output 2. Code 11 is reserved and gives y2_clk = 0 and y2_oe = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock for all dividers |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_pin | input | 3 | External setting index |
| set_pick | input | 8 | Per-setting bit choosing code A (0) or code B (1) |
| st_def0 | input | 2 | Output-state code A |
| st_def1 | input | 2 | Output-state code B |
| div_ratio | input | 21 | Three 7-bit ratios, divider 1 in bits 6:0 |
| y1_route | input | 1 | Output 1 source select |
| y2_route | input | 2 | Output 2 source select |
| y1_clk | output | 1 | Output 1 clock |
| y1_oe | output | 1 | Output 1 drive enable (0 = three-state) |
| y2_clk | output | 1 | Output 2 clock |
| y2_oe | output | 1 | Output 2 drive enable (0 = three-state) |
| pwr_down | output | 1 | Clock path powered down |

## Verification
The dividers are first run at fixed ratios while the select index sweeps all eight settings under two different per-setting patterns. This shows whether the index reaches the right stored bit and the right code. A sweep of ratios from 1 to 9 separates the odd and even duty rule, and it also separates pass-through at ratio 1 from standby at ratio 0. Ratio values and select pins are changed at arbitrary points inside a period, and the state code is toggled through 10 and 00 and back. These runs show whether updates wait for the period boundary and whether the output restarts in phase. Stepping both route fields through every code, including the reserved one, separates a wrong source choice from a wrong enable.

// File: rtl/pinsel_clkdiv_pkg.sv
`timescale 1ns/1ps
package pinsel_clkdiv_pkg;

  localparam int PCD_DIV_W   = 7;
  localparam int PCD_SEL_W   = 3;
  localparam int PCD_NUM_DIV = 3;

  typedef enum logic [1:0] {
    ST_OFF = 2'b00,
    ST_HIZ = 2'b01,
    ST_LOW = 2'b10,
    ST_ON  = 2'b11
  } st_code_e;

  // power-on values for the configuration that feeds this block
  localparam logic [1:0] PCD_DEF_CODE_A = 2'b01;
  localparam logic [1:0] PCD_DEF_CODE_B = 2'b11;
  localparam logic [7:0] PCD_DEF_PICK   = 8'b0000_0010;

  // divider counts in codes 01 and 11
  function automatic logic code_runs(input logic [1:0] c);
    return c[0];
  endfunction

  // pad is actively driven in codes 10 and 11
  function automatic logic code_drives(input logic [1:0] c);
    return c[1];
  endfunction

endpackage

// File: rtl/pcd_div_slice.sv
`timescale 1ns/1ps
module pcd_div_slice
  import pinsel_clkdiv_pkg::*;
#(
  parameter int DIV_W = PCD_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio_i,
  input  st_code_e         code_i,
  output logic             clk_o,
  output logic             bnd_o,
  output logic [DIV_W-1:0] ratio_o,
  output logic [1:0]       code_o,
  output logic [DIV_W-1:0] cnt_o,
  output logic             hi_o
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] ratio_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nx;
  st_code_e         code_q;
  logic             hi_q;
  logic             run_q;

  assign run_q  = code_runs(code_q) && (ratio_q != '0);
  assign bnd_o  = !run_q || (cnt_q == ratio_q - ONE);
  assign cnt_nx = cnt_q + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= '0;
      code_q  <= ST_OFF;
      cnt_q   <= '0;
      hi_q    <= 1'b0;
    end else if (bnd_o) begin
      ratio_q <= ratio_i;
      code_q  <= code_i;
      cnt_q   <= '0;
      hi_q    <= code_runs(code_i) && (ratio_i > ONE);
    end else begin
      cnt_q   <= cnt_nx;
      hi_q    <= cnt_nx < (ratio_q >> 1);
    end
  end

  assign clk_o   = (run_q && ratio_q == ONE) ? clk : hi_q;
  assign ratio_o = ratio_q;
  assign code_o  = code_q;
  assign cnt_o   = cnt_q;
  assign hi_o    = hi_q;

endmodule

// File: rtl/pcd_state_pick.sv
`timescale 1ns/1ps
module pcd_state_pick
  import pinsel_clkdiv_pkg::*;
#(
  parameter int SEL_W = PCD_SEL_W,
  localparam int NSET = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NSET-1:0]  set_bits,
  input  st_code_e         def_a,
  input  st_code_e         def_b,
  output st_code_e         code_o
);

  assign code_o = set_bits[sel] ? def_b : def_a;

endmodule

// File: rtl/pcd_out_route.sv
`timescale 1ns/1ps
module pcd_out_route
  import pinsel_clkdiv_pkg::*;
#(
  parameter int NUM_IN = 2,
  parameter int SEL_W  = 1
) (
  input  logic [NUM_IN-1:0]      clk_in,
  input  logic [NUM_IN-1:0][1:0] code_in,
  input  logic [SEL_W-1:0]       sel,
  output logic                   y_o,
  output logic                   oe_o
);

  always_comb begin
    y_o  = 1'b0;
    oe_o = 1'b0;
    for (int k = 0; k < NUM_IN; k++) begin
      if (int'(sel) == k) begin
        oe_o = code_drives(code_in[k]);
        y_o  = (code_in[k] == ST_ON) && clk_in[k];
      end
    end
  end

endmodule

// File: rtl/pinsel_clkdiv.sv
`timescale 1ns/1ps
module pinsel_clkdiv
  import pinsel_clkdiv_pkg::*;
#(
  parameter int DIV_W   = PCD_DIV_W,
  parameter int SEL_W   = PCD_SEL_W,
  parameter int NUM_DIV = PCD_NUM_DIV,
  localparam int NSET     = 1 << SEL_W,
  localparam int ROUTE2_W = $clog2(NUM_DIV + 1)
) (
  input  logic                     clk_src,
  input  logic                     rst_n,
  input  logic [SEL_W-1:0]         sel_pin,
  input  logic [NSET-1:0]          set_pick,
  input  logic [1:0]               st_def0,
  input  logic [1:0]               st_def1,
  input  logic [NUM_DIV*DIV_W-1:0] div_ratio,
  input  logic                     y1_route,
  input  logic [ROUTE2_W-1:0]      y2_route,
  output logic                     y1_clk,
  output logic                     y1_oe,
  output logic                     y2_clk,
  output logic                     y2_oe,
  output logic                     pwr_down
);

  st_code_e                       code_now;
  logic [NUM_DIV-1:0]             dclk_w;
  logic [NUM_DIV-1:0]             bnd_w;
  logic [NUM_DIV-1:0]             hi_w;
  logic [NUM_DIV-1:0][DIV_W-1:0]  ratio_w;
  logic [NUM_DIV-1:0][DIV_W-1:0]  cnt_w;
  logic [NUM_DIV-1:0][1:0]        codeq_w;
  logic                           pd_q;

  pcd_state_pick #(.SEL_W(SEL_W)) pick_i (
    .sel      (sel_pin),
    .set_bits (set_pick),
    .def_a    (st_code_e'(st_def0)),
    .def_b    (st_code_e'(st_def1)),
    .code_o   (code_now)
  );

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
    pcd_div_slice #(.DIV_W(DIV_W)) slice_i (
      .clk     (clk_src),
      .rst_n   (rst_n),
      .ratio_i (div_ratio[k*DIV_W +: DIV_W]),
      .code_i  (code_now),
      .clk_o   (dclk_w[k]),
      .bnd_o   (bnd_w[k]),
      .ratio_o (ratio_w[k]),
      .code_o  (codeq_w[k]),
      .cnt_o   (cnt_w[k]),
      .hi_o    (hi_w[k])
    );
  end

  pcd_out_route #(.NUM_IN(2), .SEL_W(1)) route1_i (
    .clk_in  (dclk_w[1:0]),
    .code_in (codeq_w[1:0]),
    .sel     (y1_route),
    .y_o     (y1_clk),
    .oe_o    (y1_oe)
  );

  pcd_out_route #(.NUM_IN(NUM_DIV), .SEL_W(ROUTE2_W)) route2_i (
    .clk_in  (dclk_w),
    .code_in (codeq_w),
    .sel     (y2_route),
    .y_o     (y2_clk),
    .oe_o    (y2_oe)
  );

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) pd_q <= 1'b0;
    else        pd_q <= (code_now == ST_OFF);
  end

  assign pwr_down = pd_q;

endmodule

// File: rtl/pinsel_clkdiv_chk.sv
`timescale 1ns/1ps
module pinsel_clkdiv_chk
  import pinsel_clkdiv_pkg::*;
#(
  parameter int DIV_W   = PCD_DIV_W,
  parameter int NUM_DIV = PCD_NUM_DIV
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [1:0]                    code_now,
  input logic                          pwr_down,
  input logic                          y1_oe,
  input logic                          y2_oe,
  input logic                          y2_clk,
  input logic [1:0]                    y2_route,
  input logic [NUM_DIV-1:0]            bnd,
  input logic [NUM_DIV-1:0]            dclk,
  input logic [NUM_DIV-1:0]            hi,
  input logic [NUM_DIV-1:0][DIV_W-1:0] ratio_q,
  input logic [NUM_DIV-1:0][DIV_W-1:0] cnt_q,
  input logic [NUM_DIV-1:0][1:0]       code_q
);

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (!y1_oe && !y2_oe && !pwr_down);
    end
  end

  // R6
  pwrdn_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_now == 2'b00) |=> pwr_down);

  // R12
  reserved_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y2_route == 2'b11) |-> (!y2_oe && !y2_clk));

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_chk
    // R10
    hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd[k] |=> ($stable(ratio_q[k]) && $stable(code_q[k])));

    // R5
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q[k] == 2'b10) |-> (cnt_q[k] == '0));

    // R9
    standby_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_q[k] == '0) |-> !dclk[k]);

    // R7
    duty_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q[k][0] && ratio_q[k] > DIV_W'(1) && cnt_q[k] >= (ratio_q[k] >> 1)) |-> !hi[k]);
  end

endmodule

bind pinsel_clkdiv pinsel_clkdiv_chk chk_i (
  .clk      (clk_src),
  .rst_n    (rst_n),
  .code_now (code_now),
  .pwr_down (pwr_down),
  .y1_oe    (y1_oe),
  .y2_oe    (y2_oe),
  .y2_clk   (y2_clk),
  .y2_route (y2_route),
  .bnd      (bnd_w),
  .dclk     (dclk_w),
  .hi       (hi_w),
  .ratio_q  (ratio_w),
  .cnt_q    (cnt_w),
  .code_q   (codeq_w)
);

// File: tb/pinsel_clkdiv_tb_top.sv
`timescale 1ns/1ps
module pinsel_clkdiv_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sel;
  logic [7:0]  picks;
  logic [1:0]  def0_v, def1_v;
  logic [20:0] ratios;
  logic        r1;
  logic [1:0]  r2;
  wire         y1, o1, y2, o2, pd;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  int m_r[3];
  int m_c[3];
  int m_pos[3];
  int m_hi[3];
  int m_pd;

  always #4 clk = ~clk;

  pinsel_clkdiv dut_i (
    .clk_src(clk), .rst_n(rst_n), .sel_pin(sel), .set_pick(picks),
    .st_def0(def0_v), .st_def1(def1_v), .div_ratio(ratios),
    .y1_route(r1), .y2_route(r2),
    .y1_clk(y1), .y1_oe(o1), .y2_clk(y2), .y2_oe(o2), .pwr_down(pd)
  );

  // behavioural reference, advanced once per source edge
  always @(posedge clk) begin
    int  cn;
    bit  run;
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin
        m_r[k] = 0; m_c[k] = 0; m_pos[k] = 0; m_hi[k] = 0;
      end
      m_pd = 0;
    end else begin
      cn   = picks[sel] ? int'(def1_v) : int'(def0_v);
      m_pd = (cn == 0) ? 1 : 0;
      for (int k = 0; k < 3; k++) begin
        run = (m_c[k] % 2 == 1) && (m_r[k] != 0);
        if (!run || m_pos[k] == m_r[k] - 1) begin
          m_r[k]   = int'(ratios[k*7 +: 7]);
          m_c[k]   = cn;
          m_pos[k] = 0;
          m_hi[k]  = (m_c[k] % 2 == 1 && m_r[k] > 1) ? 1 : 0;
        end else begin
          m_pos[k] = m_pos[k] + 1;
          m_hi[k]  = (m_pos[k] < m_r[k] / 2) ? 1 : 0;
        end
      end
    end
  end

  task automatic exp_out(input int d, input bit ph, output bit y, output bit oe);
    oe = (m_c[d] >= 2);
    y  = 1'b0;
    if (m_c[d] == 3) y = (m_r[d] == 1) ? ph : (m_hi[d] != 0);
  endtask

  task automatic chk(input string nm, input logic act, input bit ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", cur_req, nm, act, ex, $time);
    end
  endtask

  task automatic cmp(input bit ph);
    bit ey1, eo1, ey2, eo2;
    exp_out(r1 ? 1 : 0, ph, ey1, eo1);
    if (r2 == 2'b11) begin ey2 = 1'b0; eo2 = 1'b0; end
    else exp_out(int'(r2), ph, ey2, eo2);
    chk("y1_clk", y1, ey1);
    chk("y1_oe", o1, eo1);
    chk("y2_clk", y2, ey2);
    chk("y2_oe", o2, eo2);
    chk("pwr_down", pd, m_pd != 0);
  endtask

  always @(posedge clk) begin #2; cmp(1'b1); end
  always @(negedge clk) begin #1; cmp(1'b0); end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    sel = 3'd0; picks = 8'b0000_0010; def0_v = 2'b01; def1_v = 2'b11;
    ratios = {7'd1, 7'd3, 7'd4}; r1 = 1'b1; r2 = 2'd2;
    cur_req = "R1";
    wait_n(5);
    rst_n = 1'b1;

    cur_req = "R2";
    for (int s = 0; s < 8; s++) begin sel = 3'(s); wait_n(12); end
    picks = 8'b1010_0110;
    for (int s = 7; s >= 0; s--) begin sel = 3'(s); wait_n(12); end

    cur_req = "R3";
    picks = 8'b0000_0010; sel = 3'd1; r2 = 2'd0; wait_n(30);

    cur_req = "R7";
    r1 = 1'b1;
    for (int n = 2; n < 10; n++) begin
      ratios[13:7] = 7'(n); ratios[6:0] = 7'(11 - n); wait_n(3 * n + 6);
    end

    cur_req = "R8";
    r1 = 1'b0; ratios[6:0] = 7'd1; wait_n(20);

    cur_req = "R9";
    ratios[6:0] = 7'd0; wait_n(20);
    ratios[6:0] = 7'd4; wait_n(10);

    cur_req = "R4";
    def1_v = 2'b01; wait_n(20);
    def1_v = 2'b11; wait_n(10);

    cur_req = "R5";
    def1_v = 2'b10; wait_n(15);
    def1_v = 2'b11; wait_n(20);

    cur_req = "R6";
    def1_v = 2'b00; wait_n(15);
    def1_v = 2'b11; wait_n(20);

    cur_req = "R10";
    for (int i = 0; i < 16; i++) begin
      ratios[6:0] = 7'((i * 5) % 7 + 2); wait_n(5);
    end
    def0_v = 2'b10;
    for (int i = 0; i < 12; i++) begin
      sel = (i % 2 == 0) ? 3'd0 : 3'd1; wait_n(3);
    end
    sel = 3'd1; def0_v = 2'b01; wait_n(12);

    cur_req = "R11";
    ratios = {7'd5, 7'd3, 7'd4};
    for (int i = 0; i < 6; i++) begin r1 = ~r1; wait_n(7); end

    cur_req = "R12";
    for (int rr = 0; rr < 4; rr++) begin r2 = 2'(rr); wait_n(15); end

    wait_n(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule